// File: doc/BRIEF.md
# Fuzzy Controller Input Acquisition Port

This block collects the crisp input variables of a fuzzy controller, one byte at a time, through an RD/READY handshake. Each accepted byte lands in one of up to eight stored slots, and those slots keep their contents from one acquisition round to the next. When a round is complete, the block sends a one-cycle start pulse to the elaboration engine. It then refuses further bytes until that engine has raised and dropped its busy flag.

In master mode the host must supply the inputs in a fixed order. The block shows the slot it expects next on a 3-bit index output. In slave mode the host names the slot with a 3-bit selector that travels with each byte. The host may also close the round early with a last-input line, and any slot it did not write keeps its old value. The RD, last-input and READY lines each have a polarity bit. Holding the off-line mode input high, or changing it in either direction, places the block in a reset state.

Top module: `fzin_acq_port`

## Requirements
- R1: After reset, READY is at its inactive level, next_idx is 0, start_pulse is 0 and every stored slot is 0.
- R2: Each active RD level captures exactly one byte. READY goes active 2 clocks after RD becomes active and returns inactive 2 clocks after RD is released.
- R3: In master mode, bytes fill slots 0, 1, 2 and onward in order. next_idx names the next slot. After the last configured slot is accepted, next_idx wraps to 0 and start_pulse is high for exactly one cycle, in the same cycle READY goes active.
- R4: A cfg_num_m1 value of n configures n+1 inputs, so with n = 0 every accepted byte starts elaboration.
- R5: In slave mode, sel_id is captured together with the byte and selects its slot. A sel_id greater than cfg_num_m1 still gets READY, but no slot changes.
- R6: In slave mode, start_pulse fires once every configured slot has been written since the previous start. Writing the same slot twice counts only once.
- R7: In slave mode, an active last-input level during an accepted RD starts elaboration after that byte is stored. Slots that were not written keep their previous values.
- R8: From start_pulse until eng_busy has been seen high and then low, RD is ignored: READY stays inactive and no slot changes.
- R9: pol_rd, pol_last and pol_ready set the active level of their lines: 1 means active high and 0 means active low.
- R10: While mode_offline is high, and for 3 clocks after any change of it, the block is held in reset. This clears next_idx, READY and all slots.
- R11: In master mode, sel_id and the last-input line have no effect.
- R12: Slot k of in_bus occupies bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_offline | input | 1 | High while the controller is in its off-line phase |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_num_m1 | input | 3 | Number of inputs minus one |
| pol_ready | input | 1 | READY polarity, 1 means active high |
| pol_rd | input | 1 | RD polarity, 1 means active high |
| pol_last | input | 1 | Last-input polarity, 1 means active high |
| rd_pin | input | 1 | Host data-valid strobe |
| last_pin | input | 1 | Host last-input flag, used in slave mode |
| sel_id | input | 3 | Slot selector, used in slave mode |
| din | input | 8 | Input byte |
| eng_busy | input | 1 | Elaboration engine busy, active high |
| ready_pin | output | 1 | Byte-accepted handshake |
| next_idx | output | 3 | Next slot expected in master mode |
| start_pulse | output | 1 | One-cycle start toward the engine |
| in_bus | output | 64 | Stored slots, packed |

## Verification
The assertions assume that the configuration inputs change only while the block is held in reset. They also assume that din, sel_id and the last-input line stay steady from the rise of RD until READY answers. The stimulus changes configuration only inside an off-line window. It holds each byte's fields until the READY sample, and it spaces RD strobes at least ten clocks apart. The busy line is modelled as rising after each start and falling a few cycles later. Some RD strobes are deliberately placed inside that busy window.

// File: rtl/fzin_pkg.sv
package fzin_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_ELAB    = 2'd1
  } fzin_state_e;
endpackage

// File: rtl/fzin_rd_sync.sv
module fzin_rd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_pin,
  input  logic pol_rd,
  output logic rd_lvl,
  output logic rd_rise
);
  logic q1, q2;
  logic act;

  assign act = ~(rd_pin ^ pol_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else if (clr) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= act;
      q2 <= q1;
    end
  end

  assign rd_lvl  = q1;
  assign rd_rise = q1 & ~q2;

  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !rd_rise);
endmodule

// File: rtl/fzin_mode_hold.sv
module fzin_mode_hold #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_off,
  output logic held
);
  localparam int CW = $clog2(HOLD + 1);
  logic          mode_q;
  logic [CW-1:0] cnt;
  logic          chg;

  assign chg = mode_off ^ mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt    <= '0;
    end else begin
      mode_q <= mode_off;
      if (chg)
        cnt <= CW'(HOLD);
      else if (cnt != '0)
        cnt <= cnt - CW'(1);
    end
  end

  assign held = mode_off | chg | (cnt != '0);

  a_r10_hold_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> held);
endmodule

// File: rtl/fzin_slot_bank.sv
module fzin_slot_bank #(
  parameter int NIN = 8,
  parameter int W   = 8,
  localparam int IDW = $clog2(NIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDW-1:0]   wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [NIN*W-1:0] slots
);
  for (genvar g = 0; g < NIN; g++) begin : g_slot
    logic [W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val <= '0;
      else if (clr)
        val <= '0;
      else if (wr_en && (wr_idx == IDW'(g)))
        val <= wr_data;
    end
    assign slots[g*W +: W] = val;
  end
endmodule

// File: rtl/fzin_seq.sv
module fzin_seq
  import fzin_pkg::*;
#(
  parameter int NIN = 8,
  localparam int IDW = $clog2(NIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           rd_rise,
  input  logic           rd_lvl,
  input  logic           last_act,
  input  logic [IDW-1:0] sel_id,
  input  logic           master,
  input  logic [IDW-1:0] num_m1,
  input  logic           eng_busy,
  output logic           accept,
  output logic           wr_en,
  output logic [IDW-1:0] wr_idx,
  output logic           ready_act,
  output logic           start,
  output logic [IDW-1:0] next_idx,
  output fzin_state_e    state
);
  logic [IDW-1:0] idx;
  logic [NIN-1:0] mask, mask_nxt, full;
  logic           seen_busy;
  logic           done;

  function automatic logic [NIN-1:0] full_mask(input logic [IDW-1:0] n);
    logic [NIN-1:0] m;
    for (int i = 0; i < NIN; i++) m[i] = (i <= int'(n));
    return m;
  endfunction

  function automatic logic [NIN-1:0] one_hot(input logic [IDW-1:0] k);
    logic [NIN-1:0] m;
    for (int i = 0; i < NIN; i++) m[i] = (i == int'(k));
    return m;
  endfunction

  assign full     = full_mask(num_m1);
  assign accept   = rd_rise && (state == ST_COLLECT);
  assign wr_idx   = master ? idx : sel_id;
  assign wr_en    = accept && (master || (sel_id <= num_m1));
  assign mask_nxt = mask | (wr_en ? one_hot(wr_idx) : '0);
  assign done     = master ? (wr_en && (idx == num_m1))
                           : (accept && (last_act || ((mask_nxt & full) == full)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_COLLECT;
      idx       <= '0;
      mask      <= '0;
      seen_busy <= 1'b0;
      start     <= 1'b0;
      ready_act <= 1'b0;
    end else if (clr) begin
      state     <= ST_COLLECT;
      idx       <= '0;
      mask      <= '0;
      seen_busy <= 1'b0;
      start     <= 1'b0;
      ready_act <= 1'b0;
    end else begin
      start <= done;
      if (accept)
        ready_act <= 1'b1;
      else if (!rd_lvl)
        ready_act <= 1'b0;
      case (state)
        ST_COLLECT: begin
          if (done) begin
            state <= ST_ELAB;
            idx   <= '0;
            mask  <= '0;
          end else begin
            mask <= mask_nxt;
            if (master && wr_en) idx <= idx + IDW'(1);
          end
        end
        default: begin
          if (eng_busy) seen_busy <= 1'b1;
          if (seen_busy && !eng_busy) begin
            state     <= ST_COLLECT;
            seen_busy <= 1'b0;
          end
        end
      endcase
    end
  end

  assign next_idx = idx;

  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || clr)
    start |=> !start);
  a_r2_ready_follows_accept: assert property (@(posedge clk) disable iff (!rst_n || clr)
    accept |=> ready_act);
  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n || clr)
    master |-> (next_idx <= num_m1));
endmodule

// File: rtl/fzin_acq_port.sv
module fzin_acq_port
  import fzin_pkg::*;
#(
  parameter int NIN  = 8,
  parameter int W    = 8,
  parameter int HOLD = 3,
  localparam int IDW = $clog2(NIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_offline,
  input  logic             cfg_master,
  input  logic [IDW-1:0]   cfg_num_m1,
  input  logic             pol_ready,
  input  logic             pol_rd,
  input  logic             pol_last,
  input  logic             rd_pin,
  input  logic             last_pin,
  input  logic [IDW-1:0]   sel_id,
  input  logic [W-1:0]     din,
  input  logic             eng_busy,
  output logic             ready_pin,
  output logic [IDW-1:0]   next_idx,
  output logic             start_pulse,
  output logic [NIN*W-1:0] in_bus
);
  logic        held, rd_lvl, rd_rise, last_act;
  logic        accept, wr_en, ready_act;
  logic [IDW-1:0] wr_idx;
  fzin_state_e seq_state;

  assign last_act = ~(last_pin ^ pol_last);

  fzin_mode_hold #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .mode_off(mode_offline), .held(held)
  );

  fzin_rd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .clr(held), .rd_pin(rd_pin), .pol_rd(pol_rd),
    .rd_lvl(rd_lvl), .rd_rise(rd_rise)
  );

  fzin_seq #(.NIN(NIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(held), .rd_rise(rd_rise), .rd_lvl(rd_lvl),
    .last_act(last_act), .sel_id(sel_id), .master(cfg_master), .num_m1(cfg_num_m1),
    .eng_busy(eng_busy), .accept(accept), .wr_en(wr_en), .wr_idx(wr_idx),
    .ready_act(ready_act), .start(start_pulse), .next_idx(next_idx), .state(seq_state)
  );

  fzin_slot_bank #(.NIN(NIN), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(held), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(din), .slots(in_bus)
  );

  assign ready_pin = ~(ready_act ^ pol_ready);

  a_r8_ignore_in_elab: assert property (@(posedge clk) disable iff (!rst_n || held)
    (rd_rise && seq_state == ST_ELAB) |=> ($stable(in_bus) && !ready_act));
  a_r5_bad_id_no_write: assert property (@(posedge clk) disable iff (!rst_n || held)
    (accept && !cfg_master && sel_id > cfg_num_m1) |=> $stable(in_bus));
  a_r10_held_clears: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (!ready_act && next_idx == '0 && !start_pulse));
  a_r11_master_order: assert property (@(posedge clk) disable iff (!rst_n || held)
    (accept && cfg_master && next_idx != cfg_num_m1) |=> (next_idx == $past(next_idx) + IDW'(1)));
endmodule

// File: tb/fzin_acq_port_test.sv
`timescale 1ns/1ps
module fzin_acq_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_offline = 1'b0, cfg_master = 1'b1;
  logic [2:0] cfg_num_m1 = 3'd3;
  logic pol_ready = 1'b1, pol_rd = 1'b1, pol_last = 1'b1;
  logic rd_pin = 1'b0, last_pin = 1'b0, eng_busy = 1'b0;
  logic [2:0] sel_id = '0;
  logic [7:0] din = '0;
  logic ready_pin, start_pulse;
  logic [2:0] next_idx;
  logic [63:0] in_bus;

  int total = 0, bad = 0;
  logic [7:0] exp_v [8];
  int exp_idx = 0;
  logic [7:0] exp_mask = '0;

  always #2.5 clk = ~clk;

  fzin_acq_port uut (
    .clk(clk), .rst_n(rst_n), .mode_offline(mode_offline), .cfg_master(cfg_master),
    .cfg_num_m1(cfg_num_m1), .pol_ready(pol_ready), .pol_rd(pol_rd), .pol_last(pol_last),
    .rd_pin(rd_pin), .last_pin(last_pin), .sel_id(sel_id), .din(din), .eng_busy(eng_busy),
    .ready_pin(ready_pin), .next_idx(next_idx), .start_pulse(start_pulse), .in_bus(in_bus)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, want);
    end
  endtask

  function automatic logic [63:0] packed_exp();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = exp_v[i];
    return p;
  endfunction

  function automatic logic covers(input logic [7:0] m, input int n);
    for (int i = 0; i <= n; i++) if (!m[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic engine_round(input logic poke);
    @(negedge clk); eng_busy = 1'b1;
    if (poke) begin
      din = 8'hEE; sel_id = 3'd0; rd_pin = pol_rd;
      repeat (3) @(negedge clk);
      chk("R8 ready stays idle", ready_pin, !pol_ready);
      chk("R8 slots unchanged", in_bus, packed_exp());
      rd_pin = !pol_rd;
      repeat (3) @(negedge clk);
    end else repeat (4) @(negedge clk);
    eng_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [2:0] id, input logic lst, input logic poke);
    logic st;
    int n;
    n = int'(cfg_num_m1);
    if (cfg_master) begin
      exp_v[exp_idx] = d;
      st = (exp_idx == n);
      exp_idx = st ? 0 : exp_idx + 1;
    end else begin
      if (int'(id) <= n) begin
        exp_v[id] = d;
        exp_mask[id] = 1'b1;
      end
      st = lst || covers(exp_mask, n);
      if (st) exp_mask = '0;
    end
    @(negedge clk);
    din = d; sel_id = id; last_pin = lst ? pol_last : !pol_last; rd_pin = pol_rd;
    @(negedge clk);
    chk("R2 ready idle one clock after RD", ready_pin, !pol_ready);
    @(negedge clk);
    chk("R2 ready active two clocks after RD", ready_pin, pol_ready);
    chk("R3/R6/R7 start pulse", start_pulse, st);
    chk("R12 slot contents", in_bus, packed_exp());
    chk("R3 next index", next_idx, cfg_master ? 3'(exp_idx) : 3'd0);
    rd_pin = !pol_rd; last_pin = !pol_last;
    @(negedge clk);
    chk("R3 start single cycle", start_pulse, 1'b0);
    @(negedge clk);
    chk("R2 ready released", ready_pin, !pol_ready);
    repeat (6) @(negedge clk);
    if (st) engine_round(poke);
  endtask

  task automatic reconfig(input logic m, input logic [2:0] n, input logic pr, input logic prd, input logic pl);
    @(negedge clk); mode_offline = 1'b1;
    @(negedge clk);
    chk("R10 offline keeps ready idle", ready_pin, !pol_ready);
    cfg_master = m; cfg_num_m1 = n; pol_ready = pr; pol_rd = prd; pol_last = pl;
    rd_pin = !prd; last_pin = !pl;
    @(negedge clk); mode_offline = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) exp_v[i] = '0;
    exp_idx = 0; exp_mask = '0;
    chk("R10 slots cleared", in_bus, 64'h0);
    chk("R10 index cleared", next_idx, 3'd0);
    chk("R9 ready idle level", ready_pin, !pr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) exp_v[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready idle", ready_pin, 1'b0);
    chk("R1 index zero", next_idx, 3'd0);
    chk("R1 start low", start_pulse, 1'b0);
    chk("R1 slots zero", in_bus, 64'h0);

    // R3 and R11: master order with sel_id and last noise
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 4; k++)
        send(8'($urandom), 3'($urandom), ($urandom % 2) == 0, (r == 0));

    // R10: clear by mode change
    send(8'h5A, 3'd0, 1'b0, 1'b0);
    reconfig(1'b0, 3'd7, 1'b1, 1'b1, 1'b1);

    // R7: slave early start, R6 duplicate counts once
    send(8'h11, 3'd5, 1'b0, 1'b0);
    send(8'h22, 3'd5, 1'b0, 1'b0);
    send(8'h33, 3'd2, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) send(8'($urandom), 3'(7 - k), 1'b0, 1'b0);

    // R5: out-of-range ids on 6 inputs, random slave traffic
    reconfig(1'b0, 3'd5, 1'b1, 1'b1, 1'b1);
    send(8'h77, 3'd7, 1'b0, 1'b0);
    for (int k = 0; k < 40; k++)
      send(8'($urandom), 3'($urandom), ($urandom % 8) == 0, 1'b0);

    // R9: inverted polarities, R4: single input
    reconfig(1'b1, 3'd1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) send(8'($urandom), 3'd0, 1'b0, 1'b0);
    reconfig(1'b0, 3'd2, 1'b0, 1'b0, 1'b0);
    send(8'h44, 3'd1, 1'b0, 1'b0);
    send(8'h55, 3'd0, 1'b1, 1'b0);
    reconfig(1'b1, 3'd0, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) send(8'($urandom), 3'd0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule